// File: doc/BRIEF.md
# Programmable Bus Bit-Clock Divider

This block turns a fast reference clock into the slow bit-timing strobe that a single-wire management bus controller uses to pace negotiation and data bits. It issues no derived clock. It issues a one-cycle tick, one per division period, and the controller's state machines advance on that tick. The period is the product of three cascaded stages: a fixed prescale of four, a linear stage of `4*m + 1` set by an 8-bit timing value `m`, and a power-of-two stage `2**e` set by a 3-bit exponent `e`.

Two 8-bit timing fields feed the block, one programmed for the address phase and one for the message phase. The divider runs only while they agree. While they differ, the block reports a mismatch and holds the tick low. Settings are sampled only at a period boundary. A reprogrammed value, an exponent change or a disable therefore never cuts short a period that is already counting. Software picks the settings for a target frequency. The block only counts.

Top module: `busclk_divider`

## Requirements
- R1: While running with active timing value m (1..255) and exponent e, ticks are exactly 4*(4*m+1)*2**e reference cycles apart.
- R2: Each tick is high for exactly one reference cycle.
- R3: From idle, when enable is high, the fields match and m is nonzero at a rising edge k, the first tick is high in the cycle that follows edge k+D, where D is the R1 period.
- R4: With enable low at a period boundary, the divider stops. A period already in progress when enable falls completes and issues its tick, and then no further tick follows.
- R5: A change of m or e during a period takes effect only from the next boundary: the current gap keeps the old length and the gap after it has the new length.
- R6: The mismatch output is high exactly one cycle after the two timing fields differ at a rising edge, and low one cycle after they agree.
- R7: While the fields differ, the tick is held low, including the tick of the period that ends during the mismatch. Once they agree again, the divider restarts from idle with the R3 latency.
- R8: A timing value of 0 is not a valid setting. With m = 0 the divider stays idle and the tick stays low, and the mismatch output stays low as long as the fields agree.
- R9: Synchronous active-high reset clears all counters, the tick and the mismatch output. After release, a valid setting starts with the R3 latency.
- R10: The exponent covers 0 to 7, so the power-of-two stage scales the period by up to 128 (m=1, e=7 gives 2560 cycles).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous reset, active high |
| div_en | input | 1 | Divider run control, sampled at period boundaries |
| tmg_addr | input | 8 | Timing value for the address phase (m) |
| tmg_msg | input | 8 | Timing value for the message phase, must equal tmg_addr |
| div_exp | input | 3 | Power-of-two exponent (e) |
| bit_tick | output | 1 | One-cycle strobe at the divided rate |
| tmg_mismatch | output | 1 | High while the two timing fields disagree |

## Verification
A wrong count in any stage shows up as a tick gap that is off from the expected period. The bench measures that gap to the exact cycle, so the fault shows within one period of the faulty setting. A settings register that loads mid-period, or a run flag that ignores enable or mismatch, shows up as a gap of the wrong length, or as a tick where none may appear, at the first boundary after the stimulus. The mismatch flag is checked on the cycle after each field change, and the reset state on the cycle after reset is asserted.

// File: rtl/bdiv_pkg.sv
package bdiv_pkg;

  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_COUNT = 1'b1
  } run_state_e;

  // Mask of 2**e - 1 in a field of width w
  function automatic logic [127:0] pow2_minus1(input int unsigned e);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 128; i++) begin
      if (i < int'(e)) r[i] = 1'b1;
    end
    return r;
  endfunction

endpackage

// File: rtl/bdiv_stage.sv
module bdiv_stage #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  input  logic [W-1:0] wrap_val,
  output logic         carry
);

  logic [W-1:0] cnt;
  logic         at_zero;

  assign at_zero = (cnt == '0);
  assign carry   = step && at_zero;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (step) begin
      if (at_zero) cnt <= wrap_val;
      else         cnt <= cnt - W'(1);
    end
  end

  AST_STAGE_WRAP: assert property (@(posedge clk) disable iff (rst)
    (step && !load && at_zero) |=> (cnt == $past(wrap_val))); // R1

  AST_STAGE_DOWN: assert property (@(posedge clk) disable iff (rst)
    (step && !load && !at_zero) |=> (cnt == $past(cnt) - W'(1))); // R1

endmodule

// File: rtl/bdiv_cfg.sv
module bdiv_cfg
  import bdiv_pkg::*;
#(
  parameter int TW = 8,
  parameter int EW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          boundary,
  input  logic          en,
  input  logic [TW-1:0] tm_a,
  input  logic [TW-1:0] tm_b,
  input  logic [EW-1:0] exp_in,
  output logic [TW-1:0] m_q,
  output logic [EW-1:0] e_q,
  output logic          running,
  output logic          mis_now,
  output logic          mis_q
);

  run_state_e state;
  logic       start_ok;

  assign mis_now  = (tm_a != tm_b);
  assign start_ok = en && !mis_now && (tm_a != '0);
  assign running  = (state == RUN_COUNT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= RUN_IDLE;
      m_q   <= '0;
      e_q   <= '0;
      mis_q <= 1'b0;
    end else begin
      mis_q <= mis_now;
      if (boundary) begin
        m_q   <= tm_a;
        e_q   <= exp_in;
        state <= start_ok ? RUN_COUNT : RUN_IDLE;
      end
    end
  end

  AST_HOLD_SETTINGS: assert property (@(posedge clk) disable iff (rst)
    (running && !boundary) |=> ($stable(m_q) && $stable(e_q))); // R5

  AST_STOP_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    (boundary && !en) |=> !running); // R4

  AST_ZERO_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (boundary && (tm_a == '0)) |=> !running); // R8

  AST_MISMATCH_NO_RUN: assert property (@(posedge clk) disable iff (rst)
    (boundary && mis_now) |=> !running); // R7

endmodule

// File: rtl/bdiv_chain.sv
module bdiv_chain
  import bdiv_pkg::*;
#(
  parameter int TW      = 8,
  parameter int EW      = 3,
  parameter int PRE_DIV = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          running,
  input  logic          boundary,
  input  logic [TW-1:0] m_next,
  input  logic [EW-1:0] e_next,
  input  logic [TW-1:0] m_cur,
  input  logic [EW-1:0] e_cur,
  output logic          term
);

  localparam int PRE_W = (PRE_DIV > 2) ? $clog2(PRE_DIV) : 1;
  localparam int LIN_W = TW + 2;
  localparam int POW_W = (1 << EW) - 1;

  logic [PRE_W-1:0] pre_top;
  logic [LIN_W-1:0] lin_next, lin_cur;
  logic [POW_W-1:0] pow_next, pow_cur;
  logic             c_pre, c_lin, c_pow;

  assign pre_top  = PRE_W'(PRE_DIV - 1);
  assign lin_next = {m_next, 2'b00};
  assign lin_cur  = {m_cur, 2'b00};
  assign pow_next = POW_W'(pow2_minus1(int'(e_next)));
  assign pow_cur  = POW_W'(pow2_minus1(int'(e_cur)));

  bdiv_stage #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .load(boundary), .load_val(pre_top),
    .step(running), .wrap_val(pre_top), .carry(c_pre)
  );

  bdiv_stage #(.W(LIN_W)) u_lin (
    .clk(clk), .rst(rst), .load(boundary), .load_val(lin_next),
    .step(c_pre), .wrap_val(lin_cur), .carry(c_lin)
  );

  bdiv_stage #(.W(POW_W)) u_pow (
    .clk(clk), .rst(rst), .load(boundary), .load_val(pow_next),
    .step(c_lin), .wrap_val(pow_cur), .carry(c_pow)
  );

  assign term = c_pow;

  AST_TERM_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    term |-> running); // R4

endmodule

// File: rtl/busclk_divider.sv
module busclk_divider
  import bdiv_pkg::*;
#(
  parameter int TIMING_W = 8,
  parameter int EXP_W    = 3,
  parameter int PRE_DIV  = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                div_en,
  input  logic [TIMING_W-1:0] tmg_addr,
  input  logic [TIMING_W-1:0] tmg_msg,
  input  logic [EXP_W-1:0]    div_exp,
  output logic                bit_tick,
  output logic                tmg_mismatch
);

  logic [TIMING_W-1:0] m_q;
  logic [EXP_W-1:0]    e_q;
  logic                running, mis_now, term, boundary;

  assign boundary = term || !running;

  bdiv_cfg #(.TW(TIMING_W), .EW(EXP_W)) u_cfg (
    .clk(clk), .rst(rst), .boundary(boundary), .en(div_en),
    .tm_a(tmg_addr), .tm_b(tmg_msg), .exp_in(div_exp),
    .m_q(m_q), .e_q(e_q), .running(running),
    .mis_now(mis_now), .mis_q(tmg_mismatch)
  );

  bdiv_chain #(.TW(TIMING_W), .EW(EXP_W), .PRE_DIV(PRE_DIV)) u_chain (
    .clk(clk), .rst(rst), .running(running), .boundary(boundary),
    .m_next(tmg_addr), .e_next(div_exp), .m_cur(m_q), .e_cur(e_q),
    .term(term)
  );

  always_ff @(posedge clk) begin
    if (rst) bit_tick <= 1'b0;
    else     bit_tick <= term && !mis_now;
  end

  AST_TICK_PULSE: assert property (@(posedge clk) disable iff (rst)
    bit_tick |=> !bit_tick); // R2

  AST_TICK_CLEAN: assert property (@(posedge clk) disable iff (rst)
    bit_tick |-> !tmg_mismatch); // R7

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!bit_tick && !tmg_mismatch)); // R9

endmodule

// File: tb/tb_busclk_divider.sv
module tb_busclk_divider;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       div_en = 1'b0;
  logic [7:0] tmg_addr = 8'd0;
  logic [7:0] tmg_msg = 8'd0;
  logic [2:0] div_exp = 3'd0;
  logic       bit_tick, tmg_mismatch;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busclk_divider dut (
    .clk(clk), .rst(rst), .div_en(div_en), .tmg_addr(tmg_addr),
    .tmg_msg(tmg_msg), .div_exp(div_exp), .bit_tick(bit_tick),
    .tmg_mismatch(tmg_mismatch)
  );

  function automatic int period(input int m, input int e);
    return 4 * (4 * m + 1) * (1 << e);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // counts negedges until the tick is seen, -1 if limit passes
  task automatic gap(input int limit, output int n);
    n = -1;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (bit_tick) begin n = i; break; end
    end
  endtask

  task automatic count_ticks(input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (bit_tick) n++;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; div_en = 1'b0; tmg_addr = 8'd0; tmg_msg = 8'd0; div_exp = 3'd0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic setup(input bit en, input int a, input int b, input int e);
    div_en = en; tmg_addr = 8'(a); tmg_msg = 8'(b); div_exp = 3'(e);
  endtask

  task automatic t_reset_state();
    do_reset();
    @(negedge clk);
    chk(bit_tick == 1'b0, "R9 tick after reset", int'(bit_tick), 0);
    chk(tmg_mismatch == 1'b0, "R9 mismatch after reset", int'(tmg_mismatch), 0);
  endtask

  task automatic t_basic(input int m, input int e, input string tag);
    int d, n;
    d = period(m, e);
    do_reset();
    setup(1'b1, m, m, e);
    gap(d + 10, n);
    chk(n == d + 1, {tag, " R3 start latency"}, n, d + 1);
    @(negedge clk);
    chk(bit_tick == 1'b0, {tag, " R2 tick width"}, int'(bit_tick), 0);
    gap(d + 10, n);
    chk(n + 1 == d, {tag, " R1 period"}, n + 1, d);
    gap(d + 10, n);
    chk(n == d, {tag, " R1 period repeat"}, n, d);
  endtask

  task automatic t_change();
    int n;
    do_reset();
    setup(1'b1, 1, 1, 0);
    gap(100, n);
    chk(n == 21, "R3 latency before change", n, 21);
    setup(1'b1, 3, 3, 0);
    gap(200, n);
    chk(n == 20, "R5 old period kept", n, 20);
    gap(200, n);
    chk(n == 52, "R5 new period applied", n, 52);
  endtask

  task automatic t_disable();
    int n;
    do_reset();
    setup(1'b1, 1, 1, 1);
    gap(100, n);
    chk(n == 41, "R3 latency e=1", n, 41);
    div_en = 1'b0;
    gap(100, n);
    chk(n == 40, "R4 running period completes", n, 40);
    count_ticks(200, n);
    chk(n == 0, "R4 no ticks after disable", n, 0);
  endtask

  task automatic t_mismatch();
    int n;
    do_reset();
    setup(1'b1, 2, 2, 0);
    gap(100, n);
    chk(n == 37, "R3 latency m=2", n, 37);
    tmg_msg = 8'd3;
    #1;
    chk(tmg_mismatch == 1'b0, "R6 flag not early", int'(tmg_mismatch), 0);
    @(negedge clk);
    chk(tmg_mismatch == 1'b1, "R6 flag raised", int'(tmg_mismatch), 1);
    count_ticks(150, n);
    chk(n == 0, "R7 tick held low", n, 0);
    tmg_msg = 8'd2;
    gap(100, n);
    chk(n == 37, "R7 restart latency", n, 37);
    chk(tmg_mismatch == 1'b0, "R6 flag cleared", int'(tmg_mismatch), 0);
  endtask

  task automatic t_zero();
    int n;
    do_reset();
    setup(1'b1, 0, 0, 2);
    count_ticks(300, n);
    chk(n == 0, "R8 zero timing idle", n, 0);
    chk(tmg_mismatch == 1'b0, "R8 no mismatch for zero", int'(tmg_mismatch), 0);
  endtask

  task automatic t_reset_mid();
    int n;
    do_reset();
    setup(1'b1, 1, 2, 0);
    @(negedge clk);
    tmg_msg = 8'd1;
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(bit_tick == 1'b0 && tmg_mismatch == 1'b0, "R9 mid-run reset clears",
        int'(bit_tick), 0);
    count_ticks(25, n);
    chk(n == 0, "R9 held in reset", n, 0);
    rst = 1'b0;
    gap(100, n);
    chk(n == 21, "R9 restart after reset", n, 21);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset_state();
    t_basic(1, 0, "m1e0");
    t_basic(2, 1, "m2e1");
    t_basic(1, 7, "R10 m1e7");
    t_basic(255, 0, "m255e0");
    t_change();
    t_disable();
    t_mismatch();
    t_zero();
    t_reset_mid();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule